// File: doc/BRIEF.md
# Windowed keyed watchdog timer

A watchdog peripheral that counts down from a programmable reload value. Its counter steps once every `PRESC_DIV` pulses of an external slow-clock tick, so a 32768 Hz tick with the default divider gives 256 steps per second. A timeout of s seconds is therefore programmed as s*256-1. Software keeps the watchdog alive by writing a keyed restart command. If the counter runs out, or a restart arrives before the counter has fallen into the allowed window, a fault is raised. A fault can drive a sticky interrupt, a reset request pulse, or both.

Three word registers sit on a simple single-cycle bus: a command register (word 0), a configuration register (word 1) and a fault-status register (word 2). Reads are combinational. A read of the status word clears it. After every accepted restart the command and configuration registers ignore writes for `LOCK_SLOW` slow ticks. While the watchdog is disabled, the counter holds and the reload and window fields cannot be changed. Two halt controls let an idle or debug input freeze the counter.

Top module: `wdt_window_keyed`

## Requirements
- R1: After reset the configuration word reads 0x8FFF_0FFF: disable set, window and reload all ones, all enables clear. The status word reads 0, and `irq_o` and `rst_req_o` are low.
- R2: While the disable bit (configuration bit 31) is set, the counter holds its value and no fault occurs, however long the watchdog waits.
- R3: A configuration write that arrives while the stored disable bit is set leaves reload (bits 11:0) and window (bits 27:16) unchanged. This holds even when the same write clears the disable bit. The enable bits (12 interrupt, 13 reset, 14 halt-on-idle, 15 halt-on-debug) and bit 31 are always written.
- R4: A command write with key `KEY` in bits 31:24 and bit 0 set reloads the counter from the reload field. Restarting more often than the timeout prevents any fault.
- R5: A command write with any other key has no effect. It neither reloads the counter nor starts a write lockout.
- R6: For `LOCK_SLOW` slow ticks after an accepted restart, writes to the command and configuration words are ignored. After that they are accepted again.
- R7: When the counter is at 0 and takes a step, status bit 0 (underflow) is set and the counter reloads. The first fault after a restart with reload R comes (R+1)*PRESC_DIV slow ticks later.
- R8: A restart accepted while the watchdog is enabled and the counter is above the window field sets status bit 1 (early restart) and raises a fault. A restart at or below the window does not.
- R9: With the interrupt enable set, a fault sets `irq_o` in the same cycle as the status bit. It stays high until a status read. With the enable clear, the status bit still sets but `irq_o` stays low.
- R10: With the reset enable set, each fault produces a one-cycle `rst_req_o` pulse. With it clear, no pulse occurs.
- R11: A read of the status word returns both error bits and clears them, and `irq_o` falls with them. An event in the same cycle as the read wins.
- R12: With halt-on-idle set, the counter freezes while `idle_i` is high. Halt-on-debug does the same with `dbg_i`. With the halt bit clear, the input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| idle_i | input | 1 | System idle indication |
| dbg_i | input | 1 | Debug halt indication |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write (1) or read (0) |
| bus_addr_i | input | 2 | Word select: 0 command, 1 configuration, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the strobe is high with write low |
| irq_o | output | 1 | Sticky fault interrupt |
| rst_req_o | output | 1 | One-cycle reset request on a fault |

## Verification
A counter that steps too often, or misses steps, shows up as a fault that arrives outside the expected (R+1)*PRESC_DIV slow-tick window after a restart. A lost reload shows up as a fault during keepalive traffic, within one timeout period. A wrong lockout or freeze decision shows up at the very next readback of the configuration word. A wrong window compare shows up as a status bit and interrupt that change on the clock edge that takes the restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned DW    = 32;

  localparam int unsigned B_IRQ   = 12;
  localparam int unsigned B_RST   = 13;
  localparam int unsigned B_HIDLE = 14;
  localparam int unsigned B_HDBG  = 15;
  localparam int unsigned B_DLT   = 16;
  localparam int unsigned B_DIS   = 31;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic             dis;
    logic             halt_dbg;
    logic             halt_idle;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] reload;
  } mode_t;

  localparam mode_t MODE_RST = '{
    dis: 1'b1, halt_dbg: 1'b0, halt_idle: 1'b0, rst_en: 1'b0, irq_en: 1'b0,
    delta: {CNT_W{1'b1}}, reload: {CNT_W{1'b1}}
  };

  function automatic logic [DW-1:0] mode_pack(mode_t m);
    logic [DW-1:0] w;
    w                      = '0;
    w[CNT_W-1:0]           = m.reload;
    w[B_DLT +: CNT_W]      = m.delta;
    w[B_IRQ]               = m.irq_en;
    w[B_RST]               = m.rst_en;
    w[B_HIDLE]             = m.halt_idle;
    w[B_HDBG]              = m.halt_dbg;
    w[B_DIS]               = m.dis;
    return w;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [7:0]  KEY       = 8'hA5,
  parameter int unsigned LOCK_SLOW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    stat_i,
  output logic [DW-1:0] rdata_o,
  output mode_t         mode_o,
  output logic          restart_o,
  output logic          stat_rd_o,
  output logic          locked_o
);
  localparam int unsigned LCK_W = $clog2(LOCK_SLOW + 1);

  reg_sel_e         sel_reg;
  logic             wr_ok;
  logic             mode_wr;
  logic [LCK_W-1:0] lock_cnt;
  mode_t            mode_q;
  logic             unused_wd;

  assign sel_reg   = reg_sel_e'(addr_i);
  assign locked_o  = (lock_cnt != '0);
  assign wr_ok     = sel_i & we_i & ~locked_o;
  assign restart_o = wr_ok & (sel_reg == REG_CTRL) & (wdata_i[31:24] == KEY) & wdata_i[0];
  assign mode_wr   = wr_ok & (sel_reg == REG_MODE);
  assign stat_rd_o = sel_i & ~we_i & (sel_reg == REG_STAT);
  assign mode_o    = mode_q;
  assign unused_wd = ^{wdata_i[30:28], wdata_i[23:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
    end else if (mode_wr) begin
      mode_q.dis       <= wdata_i[B_DIS];
      mode_q.halt_dbg  <= wdata_i[B_HDBG];
      mode_q.halt_idle <= wdata_i[B_HIDLE];
      mode_q.rst_en    <= wdata_i[B_RST];
      mode_q.irq_en    <= wdata_i[B_IRQ];
      // timing fields frozen while the stored disable bit is set
      if (!mode_q.dis) begin
        mode_q.reload <= wdata_i[CNT_W-1:0];
        mode_q.delta  <= wdata_i[B_DLT +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_cnt <= '0;
    end else if (restart_o) begin
      lock_cnt <= LCK_W'(LOCK_SLOW);
    end else if (slow_tick_i && locked_o) begin
      lock_cnt <= lock_cnt - 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      case (sel_reg)
        REG_MODE: rdata_o = mode_pack(mode_q);
        REG_STAT: rdata_o = {{(DW-2){1'b0}}, stat_i};
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 128
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  slow_tick_i,
  input  logic  idle_i,
  input  logic  dbg_i,
  input  mode_t mode_i,
  input  logic  restart_i,
  output logic  unf_o,
  output logic  early_o
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run;
  logic             presc_last;
  logic             step;

  assign run        = ~mode_i.dis & ~(mode_i.halt_idle & idle_i) & ~(mode_i.halt_dbg & dbg_i);
  assign presc_last = (presc_q == PW'(PRESC_DIV - 1));
  assign step       = run & slow_tick_i & presc_last;
  assign unf_o      = step & (cnt_q == '0) & ~restart_i;
  assign early_o    = restart_i & ~mode_i.dis & (cnt_q > mode_i.delta);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= {CNT_W{1'b1}};
    end else if (restart_i) begin
      presc_q <= '0;
      cnt_q   <= mode_i.reload;
    end else if (run && slow_tick_i) begin
      presc_q <= presc_last ? '0 : presc_q + 1'b1;
      if (presc_last) cnt_q <= (cnt_q == '0) ? mode_i.reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       unf_i,
  input  logic       early_i,
  input  logic       irq_en_i,
  input  logic       rst_en_i,
  input  logic       clr_i,
  output logic [1:0] stat_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic fault;
  assign fault = unf_i | early_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o    <= '0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      // new events win over a clearing read
      stat_o    <= (clr_i ? 2'b00 : stat_o) | {early_i, unf_i};
      rst_req_o <= fault & rst_en_i;
      if (fault && irq_en_i) irq_o <= 1'b1;
      else if (clr_i)        irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_window_keyed.sv
module wdt_window_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 128,
  parameter int unsigned LOCK_SLOW = 3,
  parameter logic [7:0]  KEY       = 8'hA5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slow_tick_i,
  input  logic          idle_i,
  input  logic          dbg_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  mode_t      mode_q;
  logic       restart;
  logic       stat_rd;
  logic       locked;
  logic       unf_evt;
  logic       early_evt;
  logic [1:0] stat_q;

  wdt_regs #(.KEY(KEY), .LOCK_SLOW(LOCK_SLOW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_tick_i (slow_tick_i),
    .sel_i       (bus_sel_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .stat_i      (stat_q),
    .rdata_o     (bus_rdata_o),
    .mode_o      (mode_q),
    .restart_o   (restart),
    .stat_rd_o   (stat_rd),
    .locked_o    (locked)
  );

  wdt_core #(.PRESC_DIV(PRESC_DIV)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_tick_i (slow_tick_i),
    .idle_i      (idle_i),
    .dbg_i       (dbg_i),
    .mode_i      (mode_q),
    .restart_i   (restart),
    .unf_o       (unf_evt),
    .early_o     (early_evt)
  );

  wdt_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unf_i     (unf_evt),
    .early_i   (early_evt),
    .irq_en_i  (mode_q.irq_en),
    .rst_en_i  (mode_q.rst_en),
    .clr_i     (stat_rd),
    .stat_o    (stat_q),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdt_window_keyed_chk.sv
module wdt_window_keyed_chk
  import wdt_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_sel_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input mode_t            mode,
  input logic             locked,
  input logic             restart,
  input logic             stat_rd,
  input logic             unf,
  input logic             early,
  input logic [1:0]       stat,
  input logic [CNT_W-1:0] cnt
);
  logic mode_req, bad_key;
  assign mode_req = bus_sel_i & bus_we_i & (bus_addr_i == 2'd1);
  assign bad_key  = bus_sel_i & bus_we_i & (bus_addr_i == 2'd0) & (bus_wdata_i[31:24] != KEY);

  // R2
  a_r2_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.dis && !restart) |=> $stable(cnt));
  // R3
  a_r3_fields_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode.dis |=> (mode.reload == $past(mode.reload)) && (mode.delta == $past(mode.delta)));
  // R4
  a_r4_restart_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> cnt == $past(mode.reload));
  // R5
  a_r5_bad_key_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key |-> !restart);
  // R6
  a_r6_lock_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && mode_req) |=> $stable(mode));
  // R7
  a_r7_unf_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf |=> cnt == $past(mode.reload));
  // R9
  a_r9_irq_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat != 2'b00);
  // R10
  a_r10_rst_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> stat != 2'b00);
  // R11
  a_r11_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !unf && !early) |=> (stat == 2'b00) && !irq_o);
endmodule

bind wdt_window_keyed wdt_window_keyed_chk #(.KEY(KEY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o),
  .mode        (mode_q),
  .locked      (locked),
  .restart     (restart),
  .stat_rd     (stat_rd),
  .unf         (unf_evt),
  .early       (early_evt),
  .stat        (stat_q),
  .cnt         (u_core.cnt_q)
);

// File: tb/sim_wdt_window_keyed.sv
`timescale 1ns/1ps
module sim_wdt_window_keyed;
  localparam int PRESC    = 4;
  localparam int SLOW_PER = 4;
  localparam logic [7:0] KEY = 8'hA5;
  localparam int TOL      = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_tick_i;
  logic        idle_i = 1'b0;
  logic        dbg_i = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0, failures = 0;
  int cyc = 0;
  int ph = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) ph <= (ph == SLOW_PER - 1) ? 0 : ph + 1;
  assign slow_tick_i = (ph == 0);

  wdt_window_keyed #(.PRESC_DIV(PRESC), .LOCK_SLOW(3), .KEY(KEY)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i), .idle_i(idle_i),
    .dbg_i(dbg_i), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] mw(bit dis, bit hdbg, bit hidle, bit rst_en, bit irq_en,
                                     int dl, int rl);
    logic [11:0] d12, r12;
    d12 = dl[11:0];
    r12 = rl[11:0];
    return {dis, 3'b000, d12, hdbg, hidle, rst_en, irq_en, r12};
  endfunction

  function automatic int fault_cyc(int rl);
    return (rl + 1) * PRESC * SLOW_PER;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_sel_i = 1'b0;
  endtask

  task automatic restart();
    wr(2'd0, {KEY, 23'd0, 1'b1});
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_irq(output int t_irq, output int rst_cnt);
    int n;
    n = 0;
    while (!irq_o && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    t_irq = cyc;
    rst_cnt = rst_req_o ? 1 : 0;
    repeat (4) begin
      @(negedge clk_i);
      rst_cnt += rst_req_o ? 1 : 0;
    end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t0, t1, rc, seed;
    seed = $urandom(1234);
    settle(3);
    rst_ni = 1'b1;
    settle(2);

    // R1 reset state
    rd(2'd1, d); chk("R1 mode reset", d, 32'h8FFF_0FFF);
    rd(2'd2, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", {31'd0, irq_o}, 32'h0);
    chk("R1 rst_req reset", {31'd0, rst_req_o}, 32'h0);

    // R3 frozen fields while disabled
    wr(2'd1, mw(1, 0, 0, 0, 0, 5, 5));
    rd(2'd1, d); chk("R3 frozen dis=1", d, mw(1, 0, 0, 0, 0, 'hFFF, 'hFFF));
    wr(2'd1, mw(0, 0, 0, 1, 1, 5, 5));
    rd(2'd1, d); chk("R3 frozen on enabling write", d, mw(0, 0, 0, 1, 1, 'hFFF, 'hFFF));
    for (int i = 0; i < 4; i++) begin
      int rl, dl;
      rl = $urandom_range(16, 200);
      dl = $urandom_range(0, 4095);
      wr(2'd1, mw(0, 0, 0, 1, 1, dl, rl));
      rd(2'd1, d); chk("R3 enabled write accepted", d, mw(0, 0, 0, 1, 1, dl, rl));
    end
    wr(2'd1, mw(0, 0, 0, 1, 1, 'hFFF, 20));

    // R6 lockout after restart; R7 R9 R10 underflow timing
    restart(); t0 = cyc;
    wr(2'd1, mw(0, 0, 0, 1, 1, 'hFFF, 30));
    rd(2'd1, d); chk("R6 write ignored in lockout", d, mw(0, 0, 0, 1, 1, 'hFFF, 20));
    wait_irq(t1, rc);
    chk_rng("R7 underflow time", t1 - t0, fault_cyc(20) - TOL, fault_cyc(20) + TOL);
    chk("R10 single reset pulse", rc, 1);
    rd(2'd2, d); chk("R7 underflow status", d, 32'h1);
    chk("R11 irq cleared by read", {31'd0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R11 status cleared", d, 32'h0);

    // R4 keepalive with random gaps
    restart();
    for (int i = 0; i < 8; i++) begin
      settle($urandom_range(20, 250));
      chk("R4 no fault during keepalive", {31'd0, irq_o}, 32'h0);
      restart();
    end
    rd(2'd2, d); chk("R4 status clean", d, 32'h0);

    // R5 wrong key: no reload, no lockout
    restart(); t0 = cyc;
    settle(200);
    wr(2'd0, {8'h5A, 23'd0, 1'b1});
    wr(2'd1, mw(0, 1, 0, 1, 1, 'hFFF, 20));
    rd(2'd1, d); chk("R5 R6 no lockout after bad key", d, mw(0, 1, 0, 1, 1, 'hFFF, 20));
    wait_irq(t1, rc);
    chk_rng("R5 bad key no reload", t1 - t0, fault_cyc(20) - TOL, fault_cyc(20) + TOL);
    rd(2'd2, d);

    // R12 halt on idle / debug
    wr(2'd1, mw(0, 0, 1, 1, 1, 'hFFF, 20));
    idle_i = 1'b1;
    restart();
    settle(800);
    chk("R12 idle halt freezes", {31'd0, irq_o}, 32'h0);
    idle_i = 1'b0; t0 = cyc;
    wait_irq(t1, rc);
    chk_rng("R12 resumes after idle", t1 - t0, fault_cyc(20) - TOL, fault_cyc(20) + TOL);
    rd(2'd2, d);
    settle(20);
    wr(2'd1, mw(0, 1, 0, 1, 1, 'hFFF, 20));
    dbg_i = 1'b1;
    restart();
    settle(800);
    chk("R12 debug halt freezes", {31'd0, irq_o}, 32'h0);
    dbg_i = 1'b0;
    wait_irq(t1, rc);
    rd(2'd2, d);
    settle(20);
    wr(2'd1, mw(0, 0, 0, 1, 1, 'hFFF, 20));
    idle_i = 1'b1; dbg_i = 1'b1;
    restart(); t0 = cyc;
    wait_irq(t1, rc);
    chk_rng("R12 inputs ignored without halt bits", t1 - t0,
            fault_cyc(20) - TOL, fault_cyc(20) + TOL);
    idle_i = 1'b0; dbg_i = 1'b0;

    // R2 disabled counter holds
    wr(2'd1, mw(1, 0, 0, 1, 1, 'hFFF, 20));
    rd(2'd2, d);
    settle(1500);
    chk("R2 no irq while disabled", {31'd0, irq_o}, 32'h0);
    rd(2'd2, d); chk("R2 no status while disabled", d, 32'h0);
    wr(2'd1, mw(0, 0, 0, 1, 1, 'hFFF, 40));
    rd(2'd1, d); chk("R3 reload frozen on enable", d, mw(0, 0, 0, 1, 1, 'hFFF, 20));

    // R8 early restart window
    wr(2'd1, mw(0, 0, 0, 1, 1, 'hFFF, 40));
    restart();
    settle(20);
    wr(2'd1, mw(0, 0, 0, 1, 1, 10, 40));
    restart();
    chk("R8 R9 irq on early restart", {31'd0, irq_o}, 32'h1);
    rd(2'd2, d); chk("R8 early status bit", d, 32'h2);
    chk("R11 irq cleared after early", {31'd0, irq_o}, 32'h0);
    settle(540);
    restart();
    rd(2'd2, d); chk("R8 restart inside window", d, 32'h0);
    chk("R8 no irq inside window", {31'd0, irq_o}, 32'h0);

    // R9 R10 enables clear
    settle(20);
    wr(2'd1, mw(0, 0, 0, 0, 0, 10, 40));
    restart();
    chk("R9 irq masked", {31'd0, irq_o}, 32'h0);
    chk("R10 reset masked", {31'd0, rst_req_o}, 32'h0);
    rd(2'd2, d); chk("R9 status still set", d, 32'h2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule